// File: doc/BRIEF.md
# Display PLL Divider Search Engine

This block finds divider settings for a display clock synthesiser. It accepts a reference frequency and a desired pixel clock frequency, both as integers in hertz. It then walks a fixed space of three codes: a pre-divider code m, a feedback code n and a post-divider code fd. For each setting it works out the synthesised frequency and keeps the one that lands nearest the request. When it finishes, it reports the chosen codes together with the frequency they give and its distance from the request.

A single-cycle `start` pulse launches a search. The engine raises `busy` while it works. It ends with a one-cycle `done` pulse, and the result ports then hold the final answer. The intermediate frequency is `fin*(n+1)/(m+1)` and the output frequency is that value divided by `fd+1`. Both quotients are floored. A shared sequential multiplier and a shared restoring divider carry out all of the arithmetic. `STEP` sets how many quotient bits the divider retires per clock cycle.

Top module: `dpll_div_search`

## Requirements
- R1: After reset `busy`, `done` and `valid` are all 0.
- R2: The result matches an exhaustive search in a fixed order. The outermost loop is m from 0 up to 3. Inside it n runs from 119 down to 40, and inside that fd runs from 1 up to 31. Each m is coded directly as `m_code`, and likewise each n as `n_code` and each fd as `fd_code`.
- R3: The intermediate frequency is floor(fin*(n+1)/(m+1)). An (m, n) pair is skipped when this value is below 1000 or above 2048000000.
- R4: The output frequency is floor(intermediate/(fd+1)). A candidate whose output is 400000000 or more is rejected, so a valid `fout_hz` is always below 400000000.
- R5: A candidate replaces the best one only when its error is strictly smaller. When two candidates tie, the one reached first in the R2 order is reported.
- R6: `err_hz` equals |`fout_hz` − target| for the reported candidate.
- R7: If no candidate passes, `done` rises with `valid` 0. All three codes and `fout_hz` are then 0, and `err_hz` is all ones.
- R8: A `start` that arrives while `busy` is 1 is ignored. The running search keeps its latched inputs, and no second search follows.
- R9: `done` lasts exactly one cycle, and `busy` is 0 during that cycle. While a search runs, `err_hz` never increases.
- R10: An exact match (error 0) ends the search immediately. The inner fd loop for a pair also stops at the first accepted output that is not above the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a search (ignored while busy) |
| fin_hz | input | FREQ_W (32) | Reference frequency in Hz |
| target_hz | input | FREQ_W (32) | Requested output frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | At least one candidate passed |
| m_code | output | M_W (2) | Chosen pre-divider code |
| n_code | output | N_W (7) | Chosen feedback code |
| fd_code | output | FD_W (5) | Chosen post-divider code |
| fout_hz | output | FREQ_W (32) | Achieved output frequency |
| err_hz | output | FREQ_W (32) | Absolute error against the target |

## Verification
The bench builds the engine with every frequency limit and loop bound at its default. The only change is `STEP` = 4, so the shared divider retires four quotient bits per cycle instead of one. This cuts a full search to a few tens of thousands of cycles. That makes it possible to run several complete searches against a software model of the nested loops within the bench budget. These searches include random targets, a target above the output ceiling, an exact hit with a later tie, and a reference too slow to pass any pair.

// File: rtl/dpll_search_pkg.sv
package dpll_search_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_MUL_GO,
      S_MUL_WAIT,
      S_VDIV_WAIT,
      S_ODIV_GO,
      S_ODIV_WAIT,
      S_ADV_N,
      S_FIN
   } srch_state_t;

endpackage

// File: rtl/pll_seq_mul.sv
module pll_seq_mul #(
   parameter int AW = 32,
   parameter int BW = 7,
   localparam int PW = AW + BW,
   localparam int CW = $clog2(BW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] a,
   input  logic [BW-1:0] b,
   output logic          done,
   output logic [PW-1:0] prod
);

   logic [PW-1:0] acc_q, mc_q;
   logic [BW-1:0] mp_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         mc_q   <= '0;
         mp_q   <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            acc_q <= '0;
            mc_q  <= PW'(a);
            mp_q  <= b;
            cnt_q <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (mp_q[0]) acc_q <= acc_q + mc_q;
            mc_q  <= {mc_q[PW-2:0], 1'b0};
            mp_q  <= mp_q >> 1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(BW - 1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done = done_q;
   assign prod = acc_q;

endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
   parameter int W    = 40,
   parameter int DW   = 6,
   parameter int STEP = 1,
   localparam int WP  = ((W + STEP - 1) / STEP) * STEP,
   localparam int IT  = WP / STEP,
   localparam int CW  = $clog2(IT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [W-1:0]  dividend,
   input  logic [DW-1:0] divisor,
   output logic          done,
   output logic [W-1:0]  quotient
);

   logic [WP-1:0] dsh_q;
   logic [DW-1:0] rem_q, dvs_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, done_q;

   logic [DW:0]   r_ch [STEP+1];
   logic [STEP-1:0] qb;

   assign r_ch[0] = {1'b0, rem_q};

   for (genvar g = 0; g < STEP; g++) begin : g_stage
      logic [DW:0] sh;
      logic        ge;
      assign sh = {r_ch[g][DW-1:0], dsh_q[WP-1-g]};
      assign ge = (sh >= {1'b0, dvs_q});
      assign qb[STEP-1-g] = ge;
      assign r_ch[g+1] = ge ? (sh - {1'b0, dvs_q}) : sh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dsh_q  <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            dsh_q <= WP'(dividend);
            rem_q <= '0;
            dvs_q <= divisor;
            cnt_q <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (WP > STEP) dsh_q <= {dsh_q[WP-1-((WP>STEP)?STEP:0):0], qb};
            else           dsh_q <= WP'(qb);
            rem_q <= r_ch[STEP][DW-1:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(IT - 1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done     = done_q;
   assign quotient = dsh_q[W-1:0];

endmodule

// File: rtl/pll_search_ctrl.sv
module pll_search_ctrl
   import dpll_search_pkg::*;
#(
   parameter int          FREQ_W  = 32,
   parameter int          PW      = 39,
   parameter int          NB      = 7,
   parameter int          DW      = 6,
   parameter int          M_W     = 2,
   parameter int          N_W     = 7,
   parameter int          FD_W    = 5,
   parameter int          M_HI    = 3,
   parameter int          N_HI    = 119,
   parameter int          N_LO    = 40,
   parameter int          FD_LO   = 1,
   parameter int          FD_HI   = 31,
   parameter logic [63:0] VCO_MIN = 64'd1000,
   parameter logic [63:0] VCO_MAX = 64'd2048000000,
   parameter logic [63:0] OUT_MAX = 64'd400000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] fin_hz,
   input  logic [FREQ_W-1:0] target_hz,
   output logic              mul_start,
   output logic [FREQ_W-1:0] mul_a,
   output logic [NB-1:0]     mul_b,
   input  logic              mul_done,
   input  logic [PW-1:0]     mul_prod,
   output logic              div_start,
   output logic [PW-1:0]     div_dvd,
   output logic [DW-1:0]     div_dvs,
   input  logic              div_done,
   input  logic [PW-1:0]     div_quo,
   output logic              busy,
   output logic              done,
   output logic              valid,
   output logic [M_W-1:0]    m_code,
   output logic [N_W-1:0]    n_code,
   output logic [FD_W-1:0]   fd_code,
   output logic [FREQ_W-1:0] fout_hz,
   output logic [FREQ_W-1:0] err_hz
);

   localparam logic [PW-1:0]   VMIN_P = PW'(VCO_MIN);
   localparam logic [PW-1:0]   VMAX_P = PW'(VCO_MAX);
   localparam logic [PW-1:0]   OMAX_P = PW'(OUT_MAX);
   localparam logic [M_W-1:0]  M_HI_C = M_W'(M_HI);
   localparam logic [N_W-1:0]  N_HI_C = N_W'(N_HI);
   localparam logic [N_W-1:0]  N_LO_C = N_W'(N_LO);
   localparam logic [FD_W-1:0] FD_LO_C = FD_W'(FD_LO);
   localparam logic [FD_W-1:0] FD_HI_C = FD_W'(FD_HI);

   srch_state_t       st_q;
   logic [FREQ_W-1:0] fin_q, tgt_q, vco_q;
   logic [M_W-1:0]    m_q, bm_q;
   logic [N_W-1:0]    n_q, bn_q;
   logic [FD_W-1:0]   fd_q, bfd_q;
   logic [FREQ_W-1:0] bout_q, berr_q;
   logic              bval_q;

   logic [FREQ_W-1:0] out_f, diff;
   assign out_f = div_quo[FREQ_W-1:0];
   assign diff  = (out_f >= tgt_q) ? (out_f - tgt_q) : (tgt_q - out_f);

   assign mul_start = (st_q == S_MUL_GO);
   assign mul_a     = fin_q;
   assign mul_b     = NB'(n_q) + 1'b1;
   assign div_start = ((st_q == S_MUL_WAIT) && mul_done) || (st_q == S_ODIV_GO);
   assign div_dvd   = (st_q == S_ODIV_GO) ? PW'(vco_q) : mul_prod;
   assign div_dvs   = (st_q == S_ODIV_GO) ? (DW'(fd_q) + 1'b1) : (DW'(m_q) + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         fin_q  <= '0;
         tgt_q  <= '0;
         vco_q  <= '0;
         m_q    <= '0;
         n_q    <= '0;
         fd_q   <= '0;
         bm_q   <= '0;
         bn_q   <= '0;
         bfd_q  <= '0;
         bout_q <= '0;
         berr_q <= '1;
         bval_q <= 1'b0;
      end else begin
         case (st_q)
            S_IDLE: if (start) begin
               fin_q  <= fin_hz;
               tgt_q  <= target_hz;
               m_q    <= '0;
               n_q    <= N_HI_C;
               bm_q   <= '0;
               bn_q   <= '0;
               bfd_q  <= '0;
               bout_q <= '0;
               berr_q <= '1;
               bval_q <= 1'b0;
               st_q   <= S_MUL_GO;
            end
            S_MUL_GO:   st_q <= S_MUL_WAIT;
            S_MUL_WAIT: if (mul_done) st_q <= S_VDIV_WAIT;
            S_VDIV_WAIT: if (div_done) begin
               if (div_quo < VMIN_P || div_quo > VMAX_P) begin
                  st_q <= S_ADV_N;
               end else begin
                  vco_q <= div_quo[FREQ_W-1:0];
                  fd_q  <= FD_LO_C;
                  st_q  <= S_ODIV_GO;
               end
            end
            S_ODIV_GO: st_q <= S_ODIV_WAIT;
            S_ODIV_WAIT: if (div_done) begin
               if (div_quo >= OMAX_P) begin
                  if (fd_q == FD_HI_C) st_q <= S_ADV_N;
                  else begin
                     fd_q <= fd_q + 1'b1;
                     st_q <= S_ODIV_GO;
                  end
               end else begin
                  if (diff < berr_q) begin
                     bm_q   <= m_q;
                     bn_q   <= n_q;
                     bfd_q  <= fd_q;
                     bout_q <= out_f;
                     berr_q <= diff;
                     bval_q <= 1'b1;
                  end
                  if (diff == '0) st_q <= S_FIN;
                  else if (out_f <= tgt_q || fd_q == FD_HI_C) st_q <= S_ADV_N;
                  else begin
                     fd_q <= fd_q + 1'b1;
                     st_q <= S_ODIV_GO;
                  end
               end
            end
            S_ADV_N: begin
               if (n_q == N_LO_C) begin
                  if (m_q == M_HI_C) st_q <= S_FIN;
                  else begin
                     m_q  <= m_q + 1'b1;
                     n_q  <= N_HI_C;
                     st_q <= S_MUL_GO;
                  end
               end else begin
                  n_q  <= n_q - 1'b1;
                  st_q <= S_MUL_GO;
               end
            end
            S_FIN:   st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy    = (st_q != S_IDLE) && (st_q != S_FIN);
   assign done    = (st_q == S_FIN);
   assign valid   = bval_q;
   assign m_code  = bm_q;
   assign n_code  = bn_q;
   assign fd_code = bfd_q;
   assign fout_hz = bout_q;
   assign err_hz  = berr_q;

endmodule

// File: rtl/dpll_div_search.sv
module dpll_div_search #(
   parameter int          FREQ_W  = 32,
   parameter int          STEP    = 1,
   parameter int          M_HI    = 3,
   parameter int          N_HI    = 119,
   parameter int          N_LO    = 40,
   parameter int          FD_LO   = 1,
   parameter int          FD_HI   = 31,
   parameter logic [63:0] VCO_MIN = 64'd1000,
   parameter logic [63:0] VCO_MAX = 64'd2048000000,
   parameter logic [63:0] OUT_MAX = 64'd400000000,
   localparam int M_W  = (M_HI < 1) ? 1 : $clog2(M_HI + 1),
   localparam int N_W  = $clog2(N_HI + 1),
   localparam int FD_W = $clog2(FD_HI + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] fin_hz,
   input  logic [FREQ_W-1:0] target_hz,
   output logic              busy,
   output logic              done,
   output logic              valid,
   output logic [M_W-1:0]    m_code,
   output logic [N_W-1:0]    n_code,
   output logic [FD_W-1:0]   fd_code,
   output logic [FREQ_W-1:0] fout_hz,
   output logic [FREQ_W-1:0] err_hz
);

   localparam int NB   = $clog2(N_HI + 2);
   localparam int PW   = FREQ_W + NB;
   localparam int DMAX = (M_HI > FD_HI) ? M_HI : FD_HI;
   localparam int DW   = $clog2(DMAX + 2);

   if (STEP < 1 || STEP >= PW) begin : g_bad_step
      $error("STEP must lie in 1..PW-1");
   end
   if (N_LO > N_HI || FD_LO > FD_HI) begin : g_bad_bounds
      $error("loop bounds reversed");
   end
   if (VCO_MAX >= (64'd1 << FREQ_W) || OUT_MAX > VCO_MAX + 64'd1) begin : g_bad_limits
      $error("frequency limits do not fit FREQ_W");
   end

   logic              mul_start, mul_done;
   logic [FREQ_W-1:0] mul_a;
   logic [NB-1:0]     mul_b;
   logic [PW-1:0]     mul_prod;
   logic              div_start, div_done;
   logic [PW-1:0]     div_dvd, div_quo;
   logic [DW-1:0]     div_dvs;

   pll_search_ctrl #(
      .FREQ_W(FREQ_W), .PW(PW), .NB(NB), .DW(DW),
      .M_W(M_W), .N_W(N_W), .FD_W(FD_W),
      .M_HI(M_HI), .N_HI(N_HI), .N_LO(N_LO), .FD_LO(FD_LO), .FD_HI(FD_HI),
      .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX), .OUT_MAX(OUT_MAX)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .fin_hz(fin_hz), .target_hz(target_hz),
      .mul_start(mul_start), .mul_a(mul_a), .mul_b(mul_b),
      .mul_done(mul_done), .mul_prod(mul_prod),
      .div_start(div_start), .div_dvd(div_dvd), .div_dvs(div_dvs),
      .div_done(div_done), .div_quo(div_quo),
      .busy(busy), .done(done), .valid(valid),
      .m_code(m_code), .n_code(n_code), .fd_code(fd_code),
      .fout_hz(fout_hz), .err_hz(err_hz)
   );

   pll_seq_mul #(.AW(FREQ_W), .BW(NB)) u_mul (
      .clk(clk), .rst_n(rst_n), .start(mul_start),
      .a(mul_a), .b(mul_b), .done(mul_done), .prod(mul_prod)
   );

   pll_seq_div #(.W(PW), .DW(DW), .STEP(STEP)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start),
      .dividend(div_dvd), .divisor(div_dvs),
      .done(div_done), .quotient(div_quo)
   );

endmodule

// File: rtl/dpll_div_search_chk.sv
module dpll_div_search_chk #(
   parameter int          FREQ_W  = 32,
   parameter int          M_HI    = 3,
   parameter int          N_HI    = 119,
   parameter int          N_LO    = 40,
   parameter int          FD_LO   = 1,
   parameter int          FD_HI   = 31,
   parameter logic [63:0] OUT_MAX = 64'd400000000,
   parameter int          M_W     = 2,
   parameter int          N_W     = 7,
   parameter int          FD_W    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              valid,
   input logic [M_W-1:0]    m_code,
   input logic [N_W-1:0]    n_code,
   input logic [FD_W-1:0]   fd_code,
   input logic [FREQ_W-1:0] fout_hz,
   input logic [FREQ_W-1:0] err_hz
);

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r9_err_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (err_hz <= $past(err_hz)));

   a_r4_out_below_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (done && valid) |-> (64'(fout_hz) < OUT_MAX));

   a_r2_codes_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (done && valid) |-> (m_code <= M_W'(M_HI) && n_code >= N_W'(N_LO) &&
                           n_code <= N_W'(N_HI) && fd_code >= FD_W'(FD_LO) &&
                           fd_code <= FD_W'(FD_HI)));

   a_r7_empty_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !valid) |-> (err_hz == '1 && m_code == '0 && n_code == '0 &&
                            fd_code == '0 && fout_hz == '0));

   a_r8_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

endmodule

bind dpll_div_search dpll_div_search_chk #(
   .FREQ_W(FREQ_W), .M_HI(M_HI), .N_HI(N_HI), .N_LO(N_LO),
   .FD_LO(FD_LO), .FD_HI(FD_HI), .OUT_MAX(OUT_MAX),
   .M_W(M_W), .N_W(N_W), .FD_W(FD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .valid(valid), .m_code(m_code), .n_code(n_code), .fd_code(fd_code),
   .fout_hz(fout_hz), .err_hz(err_hz)
);

// File: tb/tb_dpll_div_search.sv
module tb_dpll_div_search;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] fin = '0;
   logic [31:0] tgt = '0;
   logic        busy, done, valid;
   logic [1:0]  m_code;
   logic [6:0]  n_code;
   logic [4:0]  fd_code;
   logic [31:0] fout_hz, err_hz;

   int n_chk = 0;
   int n_fail = 0;
   int cyc_total = 0;

   always #10 clk = ~clk;

   dpll_div_search #(.STEP(4)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .fin_hz(fin), .target_hz(tgt),
      .busy(busy), .done(done), .valid(valid),
      .m_code(m_code), .n_code(n_code), .fd_code(fd_code),
      .fout_hz(fout_hz), .err_hz(err_hz)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic ref_search(input longint unsigned f, input longint unsigned t,
                             output int rm, output int rn, output int rfd,
                             output longint unsigned rout, output longint unsigned rerr,
                             output bit rval);
      longint unsigned best;
      best = 64'hFFFF_FFFF_FFFF_FFFF;
      rm = 0; rn = 0; rfd = 0; rout = 0; rval = 0;
      for (int m = 0; m <= 3; m++) begin
         for (int n = 119; n > 39; n--) begin
            longint unsigned fv;
            fv = f * longint'(n + 1) / longint'(m + 1);
            if (fv < 1000 || fv > 2048000000) continue;
            for (int fd = 1; fd <= 31; fd++) begin
               longint unsigned o, d;
               o = fv / longint'(fd + 1);
               if (o >= 400000000) continue;
               d = (o > t) ? o - t : t - o;
               if (d < best) begin
                  best = d; rm = m; rn = n; rfd = fd; rout = o; rval = 1;
               end
            end
         end
      end
      rerr = rval ? best : 64'hFFFF_FFFF;
   endtask

   task automatic launch(input logic [31:0] f, input logic [31:0] t, output int cyc);
      @(negedge clk);
      fin = f; tgt = t; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 120000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic compare_ref(input logic [31:0] f, input logic [31:0] t, input string req);
      int rm, rn, rfd;
      longint unsigned rout, rerr;
      bit rval;
      ref_search(64'(f), 64'(t), rm, rn, rfd, rout, rerr, rval);
      check(done == 1'b1, {req, " done"}, longint'(done), 1);
      check(valid == rval, {req, " valid"}, longint'(valid), longint'(rval));
      check(int'(m_code) == rm, {req, " m"}, longint'(m_code), longint'(rm));
      check(int'(n_code) == rn, {req, " n"}, longint'(n_code), longint'(rn));
      check(int'(fd_code) == rfd, {req, " fd"}, longint'(fd_code), longint'(rfd));
      check(64'(fout_hz) == rout, {req, " fout"}, longint'(fout_hz), longint'(rout));
      check(64'(err_hz) == rerr, {req, " R6 err"}, longint'(err_hz), longint'(rerr));
   endtask

   task automatic t_reset;
      check(busy == 1'b0, "R1 busy", longint'(busy), 0);
      check(done == 1'b0, "R1 done", longint'(done), 0);
      check(valid == 1'b0, "R1 valid", longint'(valid), 0);
   endtask

   // R5 exact hit at m0 n119 fd3 beats the later tie at m1 n119 fd1; R10 early end
   task automatic t_exact;
      int cyc;
      launch(32'd10000000, 32'd300000000, cyc);
      compare_ref(32'd10000000, 32'd300000000, "R5 exact");
      check(m_code == 2'd0 && n_code == 7'd119 && fd_code == 5'd3, "R5 earliest tie",
            longint'({m_code, n_code, fd_code}), longint'({2'd0, 7'd119, 5'd3}));
      check(err_hz == 32'd0, "R6 zero err", longint'(err_hz), 0);
      check(cyc < 400, "R10 early end cycles", longint'(cyc), 400);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R9 done one cycle",
            longint'({done, busy}), 0);
   endtask

   task automatic t_busy_ignore;
      int cyc;
      bit extra;
      @(negedge clk);
      fin = 32'd10000000; tgt = 32'd300000000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R8 busy after start", longint'(busy), 1);
      repeat (3) @(negedge clk);
      tgt = 32'd123456789; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
      check(err_hz == 32'd0 && fout_hz == 32'd300000000, "R8 latched target kept",
            longint'(fout_hz), 300000000);
      extra = 0;
      repeat (20) begin
         @(negedge clk);
         if (busy || done) extra = 1;
      end
      check(!extra, "R8 no second search", longint'(extra), 0);
   endtask

   task automatic t_none;
      int cyc;
      launch(32'd5, 32'd100000000, cyc);
      compare_ref(32'd5, 32'd100000000, "R7 none");
      check(valid == 1'b0 && err_hz == 32'hFFFF_FFFF, "R7 empty result",
            longint'(err_hz), longint'(32'hFFFF_FFFF));
   endtask

   task automatic t_over_ceiling;
      int cyc;
      launch(32'd27000000, 32'd500000000, cyc);
      compare_ref(32'd27000000, 32'd500000000, "R4 ceiling");
      check(fout_hz < 32'd400000000, "R4 below ceiling", longint'(fout_hz), 400000000);
   endtask

   task automatic t_random;
      for (int k = 0; k < 2; k++) begin
         int cyc;
         logic [31:0] t;
         t = $urandom_range(390000000, 150000000);
         launch(32'd27000000, t, cyc);
         compare_ref(32'd27000000, t, "R2 R3 random");
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_exact();
      t_busy_ignore();
      t_none();
      t_over_ceiling();
      t_random();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule